// File: doc/BRIEF.md
# 32-Pin Parallel I/O Port Controller

This block is a general-purpose I/O port that sits behind a small register bus with an address, a write-data word, a read-data word and separate read and write strobes. Software programs every per-pin control mask through a pair of write-one offsets, one that sets and one that clears the addressed bits, and reads the mask back at a third offset. The port keeps an output-data mask, drives pin levels and output enables, samples pin inputs into a pin-data register and raises a level interrupt when a sampled input changes.

Any pin can be released from port control and given to one of two on-chip peripherals, called A and B. A per-pin select bit decides which peripheral sees the pin's input and which peripheral's output and enable reach the pin. Pins whose external driver has let go are flagged as undriven, and for those pins a pin-data read returns the pull-up setting. The glitch-filter and multi-drive masks are storage only and affect nothing else.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the port-control status (offset 0x08) reads 0xFFFFFFFF, the output-enable status (0x18), interrupt status (0x4C) and pin data (0x3C) read zero, and `irq` is low.
- R2: Each mask has a set offset, a clear offset and a status offset: port control 0x00/0x04/0x08, output enable 0x10/0x14/0x18, glitch filter 0x20/0x24/0x28, interrupt mask 0x40/0x44/0x48, multi-drive 0x50/0x54/0x58, pull-up 0x64/0x60/0x68, peripheral select 0x74/0x70/0x78 (bit 1 means B), output-write enable 0xA0/0xA4/0xA8. A write sets or clears exactly the bits written as 1.
- R3: Writing 1-bits to 0x30 sets and to 0x34 clears output-data bits (readable at 0x38); the level on `pin_out` of a port-controlled pin follows such a write only where the pin is output-enabled at the time of the write, and otherwise keeps its earlier level.
- R4: A write to 0x38 replaces only the output-data bits whose output-write-enable bit is 1, and drives those bits' pin levels to the written values; every other bit keeps its value.
- R5: A port-controlled pin that is not output-enabled is sampled every clock into pin data; a pin that is output-enabled keeps its stored pin-data bit whatever its input does.
- R6: A pin-data read returns, for each bit whose `pin_undriven` flag was sampled high, the pull-up status bit, and the sampled level otherwise.
- R7: Every change of a sampled pin-data bit sets that pin's interrupt-status bit; `irq` is high exactly when some interrupt-status bit and the matching mask bit are both 1.
- R8: Reading 0x4C returns the interrupt status and clears it, so `irq` falls after the read; a change sampled on the same clock is kept.
- R9: For a pin not under port control, `pin_in` is passed to `pa_in` when its select bit is 0 and to `pb_in` when it is 1; such a pin is never sampled into pin data and never sets interrupt status.
- R10: For a pin not under port control, `pin_out` and `pin_oe` come from the selected peripheral's output and enable; for a port-controlled pin `pin_oe` is its output-enable bit.
- R11: Offsets decode modulo 0x200; reads of set, clear or unused offsets return zero; writes to status offsets other than 0x38, and to unused offsets, change nothing. `bus_rd` and `bus_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NPINS | Read data, valid after the read edge, held until the next read |
| pin_in | input | NPINS | Levels present on the pins |
| pin_undriven | input | NPINS | Per-pin flag: no external driver on the pin |
| pin_out | output | NPINS | Level driven onto each pin |
| pin_oe | output | NPINS | Output enable for each pin |
| pa_in | output | NPINS | Pin inputs routed to peripheral A |
| pb_in | output | NPINS | Pin inputs routed to peripheral B |
| pa_out | input | NPINS | Peripheral A output levels |
| pa_oe | input | NPINS | Peripheral A output enables |
| pb_out | input | NPINS | Peripheral B output levels |
| pb_oe | input | NPINS | Peripheral B output enables |
| irq | output | 1 | Level interrupt |

## Verification
A write lands on the clock edge that samples `bus_wr`, so masks and pin levels change right after that edge, and a read returns its word after the one edge that samples `bus_rd`. A pin input is captured, its change recorded in interrupt status and `irq` updated all on the first edge after the input moves, while the peripheral routing of inputs is combinational. The bench drives every stimulus on the falling edge and samples one falling edge later, exactly one register stage after the cause, and reapplies reset before each scenario so every expected value follows from the requirements alone.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int OFS_W    = 9;
    localparam int OFS_MASK = (1 << OFS_W) - 1;

    localparam int OF_PIO_SET  = 'h000;
    localparam int OF_PIO_CLR  = 'h004;
    localparam int OF_PIO_STAT = 'h008;
    localparam int OF_OE_SET   = 'h010;
    localparam int OF_OE_CLR   = 'h014;
    localparam int OF_OE_STAT  = 'h018;
    localparam int OF_FLT_SET  = 'h020;
    localparam int OF_FLT_CLR  = 'h024;
    localparam int OF_FLT_STAT = 'h028;
    localparam int OF_OD_SET   = 'h030;
    localparam int OF_OD_CLR   = 'h034;
    localparam int OF_OD_DATA  = 'h038;
    localparam int OF_PIN_DATA = 'h03C;
    localparam int OF_IRQ_EN   = 'h040;
    localparam int OF_IRQ_DIS  = 'h044;
    localparam int OF_IRQ_MASK = 'h048;
    localparam int OF_IRQ_STAT = 'h04C;
    localparam int OF_MD_SET   = 'h050;
    localparam int OF_MD_CLR   = 'h054;
    localparam int OF_MD_STAT  = 'h058;
    localparam int OF_PU_CLR   = 'h060;
    localparam int OF_PU_SET   = 'h064;
    localparam int OF_PU_STAT  = 'h068;
    localparam int OF_SEL_A    = 'h070;
    localparam int OF_SEL_B    = 'h074;
    localparam int OF_SEL_STAT = 'h078;
    localparam int OF_OW_SET   = 'h0A0;
    localparam int OF_OW_CLR   = 'h0A4;
    localparam int OF_OW_STAT  = 'h0A8;

    typedef enum logic [4:0] {
        RG_NONE,
        RG_PIO_SET, RG_PIO_CLR, RG_PIO_STAT,
        RG_OE_SET,  RG_OE_CLR,  RG_OE_STAT,
        RG_FLT_SET, RG_FLT_CLR, RG_FLT_STAT,
        RG_OD_SET,  RG_OD_CLR,  RG_OD_DATA, RG_PIN_DATA,
        RG_IRQ_EN,  RG_IRQ_DIS, RG_IRQ_MASK, RG_IRQ_STAT,
        RG_MD_SET,  RG_MD_CLR,  RG_MD_STAT,
        RG_PU_CLR,  RG_PU_SET,  RG_PU_STAT,
        RG_SEL_A,   RG_SEL_B,   RG_SEL_STAT,
        RG_OW_SET,  RG_OW_CLR,  RG_OW_STAT
    } reg_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_e              sel
);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs = addr & ADDR_W'(OFS_MASK);
        sel = RG_NONE;
        case (ofs)
            ADDR_W'(OF_PIO_SET):  sel = RG_PIO_SET;
            ADDR_W'(OF_PIO_CLR):  sel = RG_PIO_CLR;
            ADDR_W'(OF_PIO_STAT): sel = RG_PIO_STAT;
            ADDR_W'(OF_OE_SET):   sel = RG_OE_SET;
            ADDR_W'(OF_OE_CLR):   sel = RG_OE_CLR;
            ADDR_W'(OF_OE_STAT):  sel = RG_OE_STAT;
            ADDR_W'(OF_FLT_SET):  sel = RG_FLT_SET;
            ADDR_W'(OF_FLT_CLR):  sel = RG_FLT_CLR;
            ADDR_W'(OF_FLT_STAT): sel = RG_FLT_STAT;
            ADDR_W'(OF_OD_SET):   sel = RG_OD_SET;
            ADDR_W'(OF_OD_CLR):   sel = RG_OD_CLR;
            ADDR_W'(OF_OD_DATA):  sel = RG_OD_DATA;
            ADDR_W'(OF_PIN_DATA): sel = RG_PIN_DATA;
            ADDR_W'(OF_IRQ_EN):   sel = RG_IRQ_EN;
            ADDR_W'(OF_IRQ_DIS):  sel = RG_IRQ_DIS;
            ADDR_W'(OF_IRQ_MASK): sel = RG_IRQ_MASK;
            ADDR_W'(OF_IRQ_STAT): sel = RG_IRQ_STAT;
            ADDR_W'(OF_MD_SET):   sel = RG_MD_SET;
            ADDR_W'(OF_MD_CLR):   sel = RG_MD_CLR;
            ADDR_W'(OF_MD_STAT):  sel = RG_MD_STAT;
            ADDR_W'(OF_PU_CLR):   sel = RG_PU_CLR;
            ADDR_W'(OF_PU_SET):   sel = RG_PU_SET;
            ADDR_W'(OF_PU_STAT):  sel = RG_PU_STAT;
            ADDR_W'(OF_SEL_A):    sel = RG_SEL_A;
            ADDR_W'(OF_SEL_B):    sel = RG_SEL_B;
            ADDR_W'(OF_SEL_STAT): sel = RG_SEL_STAT;
            ADDR_W'(OF_OW_SET):   sel = RG_OW_SET;
            ADDR_W'(OF_OW_CLR):   sel = RG_OW_CLR;
            ADDR_W'(OF_OW_STAT):  sel = RG_OW_STAT;
            default:              sel = RG_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] pin_float,
    input  logic [NPINS-1:0] cap_mask,
    output logic [NPINS-1:0] pdat_q,
    output logic [NPINS-1:0] flt_q,
    output logic [NPINS-1:0] chg
);

    logic [NPINS-1:0] pdat_d;
    logic [NPINS-1:0] flt_d;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (cap_mask[i]) begin
                flt_d[i]  = pin_float[i];
                pdat_d[i] = pin_float[i] ? 1'b0 : pin_lvl[i];
            end else begin
                flt_d[i]  = flt_q[i];
                pdat_d[i] = pdat_q[i];
            end
        end
        chg = (pdat_d ^ pdat_q) & cap_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdat_q <= '0;
            flt_q  <= '1;
        end else begin
            pdat_q <= pdat_d;
            flt_q  <= flt_d;
        end
    end

    // R5: pins outside the capture mask keep their stored level
    a_r5_hold_uncaptured: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pdat_q ^ $past(pdat_q)) & ~$past(cap_mask)) == '0));

endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] pio_own,
    input  logic [NPINS-1:0] sel_b,
    input  logic [NPINS-1:0] oe_mask,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pa_out,
    input  logic [NPINS-1:0] pa_oe,
    input  logic [NPINS-1:0] pb_out,
    input  logic [NPINS-1:0] pb_oe,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pa_in,
    output logic [NPINS-1:0] pb_in
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        always_comb begin
            if (pio_own[g]) begin
                pin_out[g] = lvl[g];
                pin_oe[g]  = oe_mask[g];
            end else if (sel_b[g]) begin
                pin_out[g] = pb_out[g];
                pin_oe[g]  = pb_oe[g];
            end else begin
                pin_out[g] = pa_out[g];
                pin_oe[g]  = pa_oe[g];
            end
            pa_in[g] = pin_in[g] & ~pio_own[g] & ~sel_b[g];
            pb_in[g] = pin_in[g] & ~pio_own[g] &  sel_b[g];
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_undriven,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pa_in,
    output logic [NPINS-1:0]  pb_in,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe,
    output logic              irq
);

    typedef logic [NPINS-1:0] mask_t;

    typedef struct packed {
        mask_t pio;
        mask_t oe;
        mask_t flt;
        mask_t od;
        mask_t lvl;
        mask_t ien;
        mask_t ist;
        mask_t md;
        mask_t pu;
        mask_t selb;
        mask_t owe;
        mask_t rdata;
    } state_t;

    state_t st_q, st_d;
    reg_e   sel;
    mask_t  pdat_q, flt_q, chg, drv_ok;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sample #(.NPINS(NPINS)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_in),
        .pin_float (pin_undriven),
        .cap_mask  (st_q.pio & ~st_q.oe),
        .pdat_q    (pdat_q),
        .flt_q     (flt_q),
        .chg       (chg)
    );

    gpio_pin_route #(.NPINS(NPINS)) u_route (
        .pio_own (st_q.pio),
        .sel_b   (st_q.selb),
        .oe_mask (st_q.oe),
        .lvl     (st_q.lvl),
        .pin_in  (pin_in),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pa_in   (pa_in),
        .pb_in   (pb_in)
    );

    always_comb begin
        st_d   = st_q;
        drv_ok = st_q.oe & st_q.pio;
        if (bus_wr) begin
            case (sel)
                RG_PIO_SET: st_d.pio  = st_q.pio  |  bus_wdata;
                RG_PIO_CLR: st_d.pio  = st_q.pio  & ~bus_wdata;
                RG_OE_SET:  st_d.oe   = st_q.oe   |  bus_wdata;
                RG_OE_CLR:  st_d.oe   = st_q.oe   & ~bus_wdata;
                RG_FLT_SET: st_d.flt  = st_q.flt  |  bus_wdata;
                RG_FLT_CLR: st_d.flt  = st_q.flt  & ~bus_wdata;
                RG_OD_SET: begin
                    st_d.od  = st_q.od  | bus_wdata;
                    st_d.lvl = st_q.lvl | (bus_wdata & drv_ok);
                end
                RG_OD_CLR: begin
                    st_d.od  = st_q.od  & ~bus_wdata;
                    st_d.lvl = st_q.lvl & ~(bus_wdata & drv_ok);
                end
                RG_OD_DATA: begin
                    st_d.od  = (st_q.od  & ~st_q.owe) | (bus_wdata & st_q.owe);
                    st_d.lvl = (st_q.lvl & ~st_q.owe) | (bus_wdata & st_q.owe);
                end
                RG_IRQ_EN:  st_d.ien  = st_q.ien  |  bus_wdata;
                RG_IRQ_DIS: st_d.ien  = st_q.ien  & ~bus_wdata;
                RG_MD_SET:  st_d.md   = st_q.md   |  bus_wdata;
                RG_MD_CLR:  st_d.md   = st_q.md   & ~bus_wdata;
                RG_PU_SET:  st_d.pu   = st_q.pu   |  bus_wdata;
                RG_PU_CLR:  st_d.pu   = st_q.pu   & ~bus_wdata;
                RG_SEL_B:   st_d.selb = st_q.selb |  bus_wdata;
                RG_SEL_A:   st_d.selb = st_q.selb & ~bus_wdata;
                RG_OW_SET:  st_d.owe  = st_q.owe  |  bus_wdata;
                RG_OW_CLR:  st_d.owe  = st_q.owe  & ~bus_wdata;
                default: ;
            endcase
        end

        // clear-on-read; a change sampled in the same cycle survives
        st_d.ist = ((bus_rd && sel == RG_IRQ_STAT) ? '0 : st_q.ist) | chg;

        if (bus_rd) begin
            case (sel)
                RG_PIO_STAT: st_d.rdata = st_q.pio;
                RG_OE_STAT:  st_d.rdata = st_q.oe;
                RG_FLT_STAT: st_d.rdata = st_q.flt;
                RG_OD_DATA:  st_d.rdata = st_q.od;
                RG_PIN_DATA: st_d.rdata = (pdat_q & ~flt_q) | (st_q.pu & flt_q);
                RG_IRQ_MASK: st_d.rdata = st_q.ien;
                RG_IRQ_STAT: st_d.rdata = st_q.ist;
                RG_MD_STAT:  st_d.rdata = st_q.md;
                RG_PU_STAT:  st_d.rdata = st_q.pu;
                RG_SEL_STAT: st_d.rdata = st_q.selb;
                RG_OW_STAT:  st_d.rdata = st_q.owe;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pio <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |(st_q.ist & st_q.ien);

    // R11: the bus never issues a read and a write together
    a_r11_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3: set/clear writes move pin levels only on enabled port pins
    a_r3_lvl_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == RG_OD_SET || sel == RG_OD_CLR)) |=>
        (((st_q.lvl ^ $past(st_q.lvl)) & ~$past(st_q.oe & st_q.pio)) == '0));

    // R4: direct output write touches only write-enabled bits
    a_r4_direct_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RG_OD_DATA) |=>
        (((st_q.od ^ $past(st_q.od)) & ~$past(st_q.owe)) == '0));

    // R8: a status read with no concurrent change empties the status
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == RG_IRQ_STAT && chg == '0) |=> (st_q.ist == '0));

    // R9: pins handed to a peripheral never raise status
    a_r9_no_status_periph: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg & ~st_q.pio) == '0));

endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;

    localparam int NP = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [NP-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_undriven = '0;
    logic [NP-1:0] pin_out, pin_oe, pa_in, pb_in;
    logic [NP-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic          irq;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.NPINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_undriven(pin_undriven), .pin_out(pin_out),
        .pin_oe(pin_oe), .pa_in(pa_in), .pb_in(pb_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0; pin_undriven = '0;
        pa_out = '0; pa_oe = '0; pb_out = '0; pb_oe = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd('h08, v); chk("R1 port-control status", v, 32'hFFFF_FFFF);
        rd('h18, v); chk("R1 output-enable status", v, 32'h0);
        rd('h4C, v); chk("R1 interrupt status", v, 32'h0);
        rd('h3C, v); chk("R1 pin data", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        do_reset();
        wr('h10, 32'hFF); wr('h14, 32'h0F);
        rd('h18, v); chk("R2 output enable set/clear", v, 32'hF0);
        wr('h20, 32'h3); wr('h24, 32'h1);
        rd('h28, v); chk("R2 filter set/clear", v, 32'h2);
        wr('h50, 32'hC000_0000); wr('h54, 32'h4000_0000);
        rd('h58, v); chk("R2 multi-drive set/clear", v, 32'h8000_0000);
        wr('h64, 32'h0F0F); wr('h60, 32'h0F00);
        rd('h68, v); chk("R2 pull-up set/clear", v, 32'h000F);
        wr('h40, 32'h6); wr('h44, 32'h2);
        rd('h48, v); chk("R2 interrupt mask", v, 32'h4);
    endtask

    task automatic t_odata();
        logic [31:0] v;
        do_reset();
        wr('h10, 32'h0F); wr('h30, 32'hFF);
        rd('h38, v); chk("R3 output data after set", v, 32'hFF);
        chk("R3 pin level only on enabled pins", pin_out, 32'h0F);
        chk("R10 port pin enable follows mask", pin_oe, 32'h0F);
        wr('h10, 32'hF0);
        chk("R3 pin level held after enabling", pin_out, 32'h0F);
        wr('h34, 32'h03);
        rd('h38, v); chk("R3 output data after clear", v, 32'hFC);
        chk("R3 pin level after clear", pin_out, 32'h0C);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        do_reset();
        wr('hA0, 32'hF0); wr('h38, 32'hFFFF_FFFF);
        rd('h38, v); chk("R4 direct write masked", v, 32'hF0);
        chk("R4 direct write drives pins", pin_out, 32'hF0);
        wr('hA4, 32'hC0); wr('h38, 32'h0);
        rd('h38, v); chk("R4 direct write after mask shrink", v, 32'hC0);
        chk("R4 pins after second write", pin_out, 32'hC0);
        rd('hA8, v); chk("R2 write-enable status", v, 32'h30);
    endtask

    task automatic t_input();
        logic [31:0] v;
        do_reset();
        @(negedge clk); pin_in = 32'h5;
        @(negedge clk);
        chk("R7 irq stays low while unmasked", {31'b0, irq}, 32'h0);
        rd('h3C, v); chk("R5 sampled pin data", v, 32'h5);
        rd('h4C, v); chk("R7 status bits on change", v, 32'h5);
        rd('h4C, v); chk("R8 status cleared by read", v, 32'h0);
        wr('h40, 32'h1);
        @(negedge clk); pin_in = 32'h4;
        @(negedge clk);
        chk("R7 irq on masked change", {31'b0, irq}, 32'h1);
        rd('h4C, v); chk("R8 read returns status", v, 32'h1);
        chk("R8 irq falls after read", {31'b0, irq}, 32'h0);
        wr('h10, 32'h4);
        @(negedge clk); pin_in = 32'h0;
        @(negedge clk);
        rd('h3C, v); chk("R5 output-enabled pin ignored", v, 32'h4);
        rd('h4C, v); chk("R5 no status for enabled pin", v, 32'h0);
    endtask

    task automatic t_pullup();
        logic [31:0] v;
        do_reset();
        wr('h64, 32'h2);
        @(negedge clk); pin_undriven = 32'h2; pin_in = 32'h1;
        @(negedge clk);
        rd('h3C, v); chk("R6 undriven pin reads pull-up", v, 32'h3);
        wr('h60, 32'h2);
        rd('h3C, v); chk("R6 undriven pin without pull-up", v, 32'h1);
    endtask

    task automatic t_periph();
        logic [31:0] v;
        do_reset();
        wr('h04, 32'h3); wr('h74, 32'h2);
        @(negedge clk);
        pin_in = 32'h3; pa_out = '1; pa_oe = '1; pb_out = '0; pb_oe = '0;
        @(negedge clk);
        chk("R9 input to peripheral A", pa_in, 32'h1);
        chk("R9 input to peripheral B", pb_in, 32'h2);
        chk("R10 output from selected peripheral", pin_out & 32'h3, 32'h1);
        chk("R10 enable from selected peripheral", pin_oe & 32'h3, 32'h1);
        rd('h78, v); chk("R2 select status", v, 32'h2);
        rd('h4C, v); chk("R9 peripheral pins raise no status", v, 32'h0);
        rd('h3C, v); chk("R9 peripheral pins not sampled", v, 32'h0);
        wr('h70, 32'h2);
        chk("R9 reselect A", pa_in, 32'h3);
        chk("R10 reselect A output", pin_out & 32'h3, 32'h3);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        rd('h00, v); chk("R11 set offset reads zero", v, 32'h0);
        rd('h0C, v); chk("R11 unused offset reads zero", v, 32'h0);
        wr('h08, 32'h0);
        rd('h08, v); chk("R11 status write ignored", v, 32'hFFFF_FFFF);
        wr('h210, 32'h1);
        rd('h018, v); chk("R11 aliased write", v, 32'h1);
        rd('h418, v); chk("R11 aliased read", v, 32'h1);
    endtask

    initial begin
        t_reset();
        t_setclr();
        t_odata();
        t_direct();
        t_input();
        t_pullup();
        t_periph();
        t_map();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule